// File: doc/BRIEF.md
# Multi-Channel DMA Register Target

This block is the software-facing side of a DMA controller with several independent channels. A processor reaches it over a simple request/response target bus with 32-bit data. Each channel has its own small group of registers: a source address, a destination address, a byte count, a write-only reinitialise register and an interrupt mask. The transfer engines sit outside this block. Each engine receives a one-cycle launch pulse and a one-cycle reinitialise pulse from here, and returns a one-cycle completion pulse.

Software programs the two addresses and then writes the byte count, and that write starts the transfer. While the transfer runs, reading the byte count returns the programmed value. It returns zero once the transfer has finished. Completion raises a per-channel interrupt line that stays high until software writes the reinitialise register. Any access that does not decode to a legal register, or that carries illegal data, gets an error response, so the block can also serve as the default target of its bus segment.

Top module: `mcdma_target`

## Requirements
- R1: Every request cycle (`req_valid` high) gets exactly one response on the next clock cycle. `rsp_valid` is high in that cycle only, and the target never stalls.
- R2: Offset decode within the 1 KB segment works as follows. Bits [9:6] select the channel and bits [5:2] select the register: 0 source, 1 destination, 2 length, 3 reinitialise, 4 interrupt mask. The following get an error response with zero read data and change no state: a nonzero `req_addr[1:0]`, a channel index of `NUM_CH` or above, a register index above 4, or a read of register 3.
- R3: Source and destination are read/write 32-bit byte addresses. A write whose data has nonzero bits [1:0] gets an error response, and the register keeps its old value.
- R4: A length write while the channel is idle stores the value. If the value is a nonzero multiple of 4, the write also raises that channel's `chn_start` bit for exactly one cycle, in the same cycle as the response. A length that is not a multiple of 4 gets an error response, is not stored and starts nothing. A zero length is accepted and starts nothing.
- R5: While a channel is busy, reading its length register returns the stored length. The channel stays busy from the launching write until its `eng_done` pulse or a reinitialise write, and reading length returns 0 when the channel is not busy.
- R6: A write to source, destination or length while the channel is busy gets an error response and changes nothing.
- R7: Any write to the reinitialise register is accepted, whether the channel is busy or idle. It raises that channel's `chn_reset` bit for one cycle, returns the channel to idle and clears its pending interrupt. If `eng_done` arrives in the same cycle, the reinitialise write wins.
- R8: An `eng_done` pulse on a busy channel sets that channel's pending interrupt. The interrupt stays set until a reinitialise write. An `eng_done` pulse on an idle channel is ignored.
- R9: The interrupt mask register is read/write. While its value is nonzero, the channel's `irq` output is held low, but the pending interrupt is kept and shows again when the mask is cleared.
- R10: After reset, all registers read zero, no channel is busy, and `irq`, `chn_start`, `chn_reset` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte offset within the segment |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 32 | Read data, zero on writes and errors |
| eng_done | input | NUM_CH | Per-channel completion pulse from the engines |
| chn_start | output | NUM_CH | Per-channel launch pulse |
| chn_reset | output | NUM_CH | Per-channel reinitialise pulse |
| irq | output | NUM_CH | Per-channel interrupt line |

## Verification
The bench builds the block with three channels rather than the default four. This leaves channel indices 3 to 15 unmapped, so the out-of-range decode error can be reached with legal offsets. Three channels also allow two engines to finish in the same cycle while a third sits masked or idle. Because every cycle is compared against a behavioural model, concurrent cases are covered along the way: completion against reinitialise on the same channel, and writes that land while a channel is busy.

// File: rtl/mcdma_pkg.sv
package mcdma_pkg;

    localparam int WORD_W   = 32;
    localparam int OFF_W    = 10;
    localparam int CHSEL_W  = 4;
    localparam int MAX_CH   = 1 << CHSEL_W;

    typedef enum logic [2:0] {
        RG_SRC  = 3'd0,
        RG_DST  = 3'd1,
        RG_LEN  = 3'd2,
        RG_RST  = 3'd3,
        RG_MASK = 3'd4,
        RG_NONE = 3'd7
    } reg_kind_e;

    typedef struct packed {
        logic               hit;
        logic               wr;
        logic [CHSEL_W-1:0] chan;
        reg_kind_e          kind;
        logic [WORD_W-1:0]  data;
    } acc_t;

    function automatic reg_kind_e field_to_kind(input logic [3:0] f);
        case (f)
            4'd0:    return RG_SRC;
            4'd1:    return RG_DST;
            4'd2:    return RG_LEN;
            4'd3:    return RG_RST;
            4'd4:    return RG_MASK;
            default: return RG_NONE;
        endcase
    endfunction

    function automatic logic word_aligned(input logic [WORD_W-1:0] v);
        return v[1:0] == 2'b00;
    endfunction

endpackage

// File: rtl/mcdma_decode.sv
module mcdma_decode
    import mcdma_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [OFF_W-1:0]  req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output acc_t              acc,
    output logic              dec_err
);

    logic [CHSEL_W-1:0] chan;
    reg_kind_e          kind;
    logic               misalign;
    logic               no_chan;
    logic               no_reg;
    logic               bad_dir;
    logic               bad;

    always_comb begin
        chan     = req_addr[9:6];
        kind     = field_to_kind(req_addr[5:2]);
        misalign = req_addr[1:0] != 2'b00;
        no_chan  = int'(chan) >= NUM_CH;
        no_reg   = kind == RG_NONE;
        bad_dir  = !req_write && kind == RG_RST;
        bad      = misalign || no_chan || no_reg || bad_dir;

        dec_err  = req_valid && bad;
        acc.hit  = req_valid && !bad;
        acc.wr   = req_write;
        acc.chan = chan;
        acc.kind = kind;
        acc.data = req_wdata;
    end

endmodule

// File: rtl/mcdma_chan.sv
module mcdma_chan
    import mcdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  acc_t              acc,
    input  logic              done,
    output logic [WORD_W-1:0] rd_data,
    output logic              wr_err,
    output logic              start_p,
    output logic              rst_p,
    output logic              irq
);

    logic [WORD_W-1:0] src_q, dst_q, len_q, mask_q;
    logic              busy_q, pend_q, start_q, rstp_q;

    logic is_wr, is_rd, guarded, bad_data, wr_ok, do_rst, launch, finish;

    always_comb begin
        is_wr    = sel && acc.wr;
        is_rd    = sel && !acc.wr;
        guarded  = acc.kind inside {RG_SRC, RG_DST, RG_LEN};
        bad_data = !word_aligned(acc.data);
        wr_err   = is_wr && guarded && (busy_q || bad_data);
        wr_ok    = is_wr && guarded && !busy_q && !bad_data;
        do_rst   = is_wr && acc.kind == RG_RST;
        launch   = wr_ok && acc.kind == RG_LEN && (acc.data != '0);
        finish   = done && busy_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q   <= '0;
            dst_q   <= '0;
            len_q   <= '0;
            mask_q  <= '0;
            busy_q  <= 1'b0;
            pend_q  <= 1'b0;
            start_q <= 1'b0;
            rstp_q  <= 1'b0;
        end else begin
            if (wr_ok && acc.kind == RG_SRC) src_q <= acc.data;
            if (wr_ok && acc.kind == RG_DST) dst_q <= acc.data;
            if (wr_ok && acc.kind == RG_LEN) len_q <= acc.data;
            if (is_wr && acc.kind == RG_MASK) mask_q <= acc.data;

            start_q <= launch;
            rstp_q  <= do_rst;

            if (do_rst)      busy_q <= 1'b0;
            else if (launch) busy_q <= 1'b1;
            else if (finish) busy_q <= 1'b0;

            if (do_rst)      pend_q <= 1'b0;
            else if (finish) pend_q <= 1'b1;
        end
    end

    always_comb begin
        rd_data = '0;
        if (is_rd) begin
            case (acc.kind)
                RG_SRC:  rd_data = src_q;
                RG_DST:  rd_data = dst_q;
                RG_LEN:  rd_data = busy_q ? len_q : '0;
                RG_MASK: rd_data = mask_q;
                default: rd_data = '0;
            endcase
        end
    end

    assign start_p = start_q;
    assign rst_p   = rstp_q;
    assign irq     = pend_q && (mask_q == '0);

endmodule

// File: rtl/mcdma_target.sv
module mcdma_target
    import mcdma_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [9:0]        req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    input  logic [NUM_CH-1:0] eng_done,
    output logic [NUM_CH-1:0] chn_start,
    output logic [NUM_CH-1:0] chn_reset,
    output logic [NUM_CH-1:0] irq
);

    if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_param
        $error("NUM_CH out of range");
    end

    acc_t              acc;
    logic              dec_err;
    logic [WORD_W-1:0] ch_rd  [NUM_CH];
    logic [NUM_CH-1:0] ch_err;
    logic [WORD_W-1:0] rd_any;
    logic              err_any;

    mcdma_decode #(.NUM_CH(NUM_CH)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .acc       (acc),
        .dec_err   (dec_err)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel;
        assign sel = acc.hit && (acc.chan == CHSEL_W'(i));

        mcdma_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .sel     (sel),
            .acc     (acc),
            .done    (eng_done[i]),
            .rd_data (ch_rd[i]),
            .wr_err  (ch_err[i]),
            .start_p (chn_start[i]),
            .rst_p   (chn_reset[i]),
            .irq     (irq[i])
        );
    end

    always_comb begin
        rd_any = '0;
        for (int i = 0; i < NUM_CH; i++) rd_any = rd_any | ch_rd[i];
        err_any = dec_err || (|ch_err);
    end

    logic              rsp_valid_q, rsp_err_q;
    logic [WORD_W-1:0] rsp_rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= req_valid;
            rsp_err_q   <= req_valid && err_any;
            rsp_rdata_q <= (acc.hit && !acc.wr) ? rd_any : '0;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_err   = rsp_err_q;
    assign rsp_rdata = rsp_rdata_q;

endmodule

// File: rtl/mcdma_sva.sv
module mcdma_sva #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [9:0]        req_addr,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [31:0]       rsp_rdata,
    input logic [NUM_CH-1:0] eng_done,
    input logic [NUM_CH-1:0] chn_start,
    input logic [NUM_CH-1:0] chn_reset,
    input logic [NUM_CH-1:0] irq
);

    p_rsp_follows_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_rsp_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_bad_chan_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid && (int'(req_addr[9:6]) >= NUM_CH) |=> rsp_err && rsp_rdata == 32'd0);
    p_bad_align_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_addr[1:0] != 2'b00 |=> rsp_err);
    p_reset_read_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_write && req_addr[5:2] == 4'd3 |=> rsp_err);

    p_start_single_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chn_start));
    p_start_ok_rsp_r4: assert property (@(posedge clk) disable iff (rst)
        (|chn_start) |-> rsp_valid && !rsp_err);

    p_rst_ok_rsp_r7: assert property (@(posedge clk) disable iff (rst)
        (|chn_reset) |-> rsp_valid && !rsp_err);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        p_irq_cleared_r7: assert property (@(posedge clk) disable iff (rst)
            chn_reset[i] |-> !irq[i]);
        p_no_start_and_rst_r7: assert property (@(posedge clk) disable iff (rst)
            !(chn_start[i] && chn_reset[i]));
        p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[i]) |-> $past(eng_done[i]) ||
                              $past(req_valid && req_write && req_addr[5:2] == 4'd4));
    end

endmodule

bind mcdma_target mcdma_sva #(.NUM_CH(NUM_CH)) u_sva (.*);

// File: tb/mcdma_target_bench.sv
`timescale 1ns/1ps
module mcdma_target_bench;

    localparam int NCH = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [9:0]      req_addr  = '0;
    logic [31:0]     req_wdata = '0;
    logic            rsp_valid, rsp_err;
    logic [31:0]     rsp_rdata;
    logic [NCH-1:0]  eng_done = '0;
    logic [NCH-1:0]  chn_start, chn_reset, irq;

    always #2.5 clk = ~clk;

    mcdma_target #(.NUM_CH(NCH)) u_mcdma_target (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .eng_done(eng_done), .chn_start(chn_start),
        .chn_reset(chn_reset), .irq(irq)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // behavioural model state
    logic [31:0] m_src [NCH];
    logic [31:0] m_dst [NCH];
    logic [31:0] m_len [NCH];
    logic [31:0] m_msk [NCH];
    bit          m_busy[NCH];
    bit          m_pend[NCH];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [9:0] off(input int ch, input int rg);
        return 10'((ch << 6) | (rg << 2));
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_src[i] = 0; m_dst[i] = 0; m_len[i] = 0; m_msk[i] = 0;
            m_busy[i] = 0; m_pend[i] = 0;
        end
    endtask

    task automatic tick(input bit v, input bit w, input logic [9:0] a,
                        input logic [31:0] d, input logic [NCH-1:0] dn,
                        input string tag);
        bit          e_err;
        logic [31:0] e_rd;
        logic [NCH-1:0] e_start, e_rst, e_irq;
        bit          old_busy[NCH];
        int ch, rg;
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a; req_wdata = d; eng_done = dn;
        @(posedge clk);
        #1;
        ch = int'(a[9:6]); rg = int'(a[5:2]);
        e_err = 0; e_rd = 0; e_start = '0; e_rst = '0;
        for (int i = 0; i < NCH; i++) old_busy[i] = m_busy[i];
        if (v) begin
            if (a[1:0] != 0 || ch >= NCH || rg > 4 || (!w && rg == 3)) e_err = 1;
            else if (!w) begin
                case (rg)
                    0: e_rd = m_src[ch];
                    1: e_rd = m_dst[ch];
                    2: e_rd = m_busy[ch] ? m_len[ch] : 0;
                    default: e_rd = m_msk[ch];
                endcase
            end else begin
                case (rg)
                    0, 1, 2: begin
                        if (m_busy[ch] || d[1:0] != 0) e_err = 1;
                        else if (rg == 0) m_src[ch] = d;
                        else if (rg == 1) m_dst[ch] = d;
                        else begin
                            m_len[ch] = d;
                            if (d != 0) begin m_busy[ch] = 1; e_start[ch] = 1; end
                        end
                    end
                    3: begin m_busy[ch] = 0; m_pend[ch] = 0; e_rst[ch] = 1; end
                    default: m_msk[ch] = d;
                endcase
            end
        end
        for (int i = 0; i < NCH; i++)
            if (dn[i] && old_busy[i] && !e_rst[i]) begin
                m_busy[i] = 0; m_pend[i] = 1;
            end
        for (int i = 0; i < NCH; i++) e_irq[i] = m_pend[i] && m_msk[i] == 0;
        chk(rsp_valid == v, tag, "rsp_valid", 32'(rsp_valid), 32'(v));
        if (v) begin
            chk(rsp_err == e_err, tag, "rsp_err", 32'(rsp_err), 32'(e_err));
            chk(rsp_rdata == e_rd, tag, "rsp_rdata", rsp_rdata, e_rd);
        end
        chk(chn_start == e_start, tag, "chn_start", 32'(chn_start), 32'(e_start));
        chk(chn_reset == e_rst, tag, "chn_reset", 32'(chn_reset), 32'(e_rst));
        chk(irq == e_irq, tag, "irq", 32'(irq), 32'(e_irq));
    endtask

    task automatic wr(input int ch, input int rg, input logic [31:0] d, input string tag);
        tick(1, 1, off(ch, rg), d, '0, tag);
    endtask
    task automatic rd(input int ch, input int rg, input string tag);
        tick(1, 0, off(ch, rg), 0, '0, tag);
    endtask
    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) tick(0, 0, '0, 0, '0, tag);
    endtask
    task automatic done(input logic [NCH-1:0] dn, input string tag);
        tick(0, 0, '0, 0, dn, tag);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0;
        // R10: reset state
        idle(2, "R10");
        for (int c = 0; c < NCH; c++)
            for (int r = 0; r < 5; r++) if (r != 3) rd(c, r, "R10");

        // R3: source / destination round trip and misaligned rejection
        wr(0, 0, 32'h0000_1000, "R3");
        wr(0, 1, 32'h0000_2000, "R3");
        rd(0, 0, "R3"); rd(0, 1, "R3");
        wr(0, 0, 32'h0000_1002, "R3");
        wr(0, 1, 32'h0000_2001, "R3");
        rd(0, 0, "R3"); rd(0, 1, "R3");

        // R2: decode errors
        tick(1, 1, 10'h002, 32'h4, '0, "R2");
        tick(1, 0, 10'h001, 0, '0, "R2");
        wr(3, 0, 32'h40, "R2");
        rd(15, 1, "R2");
        wr(0, 5, 32'h8, "R2");
        rd(1, 15, "R2");
        rd(0, 3, "R2");
        rd(0, 0, "R2");

        // R4 / R5 / R6 / R8 / R9 / R7 on channel 0
        wr(0, 2, 32'd64, "R4");
        rd(0, 2, "R5");
        wr(0, 0, 32'h0000_3000, "R6");
        wr(0, 1, 32'h0000_3000, "R6");
        wr(0, 2, 32'd128, "R6");
        rd(0, 0, "R6"); rd(0, 2, "R6");
        done(3'b001, "R8");
        rd(0, 2, "R5");
        idle(3, "R8");
        done(3'b001, "R8");
        wr(0, 4, 32'h1, "R9");
        rd(0, 4, "R9");
        idle(2, "R9");
        wr(0, 4, 32'h0, "R9");
        idle(1, "R9");
        wr(0, 3, 32'hDEAD_BEEF, "R7");
        idle(1, "R7");

        // R4: illegal and zero lengths
        wr(1, 2, 32'd66, "R4");
        rd(1, 2, "R4");
        wr(1, 2, 32'd0, "R4");
        rd(1, 2, "R4");
        wr(1, 0, 32'h10, "R4");

        // R7: reinitialise while busy, later done ignored
        wr(1, 2, 32'd16, "R7");
        rd(1, 2, "R7");
        wr(1, 3, 32'h0, "R7");
        rd(1, 2, "R7");
        done(3'b010, "R8");
        idle(1, "R8");

        // R8 / R9: two channels finishing together, one masked
        wr(2, 4, 32'h8000_0000, "R9");
        wr(1, 2, 32'd4, "R8");
        wr(2, 2, 32'd256, "R8");
        done(3'b111, "R8");
        idle(2, "R9");
        wr(2, 4, 32'h0, "R9");
        wr(1, 3, 32'h1, "R7");
        wr(2, 3, 32'h1, "R7");

        // R7: reinitialise and done in the same cycle
        wr(0, 2, 32'd8, "R7");
        tick(1, 1, off(0, 3), 32'h0, 3'b001, "R7");
        idle(1, "R7");
        rd(0, 2, "R7");

        // R1: back-to-back requests
        rd(2, 0, "R1"); rd(2, 1, "R1"); wr(2, 0, 32'h44, "R1"); rd(2, 0, "R1");
        idle(2, "R1");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule